// File: doc/BRIEF.md
# Bus Interrupt Acknowledge Sequencer

This block sits on the processor side of a shared external bus. It answers an interrupt raised by a peripheral. A peripheral pulls the shared request line high. When the core signals that it can take an interrupt, the sequencer raises the acknowledge line, which grants the bus to the requester. The requester then drives its vector number onto the low eight data lines and lets go of the request line. The acknowledge line is still high at that moment, and this is how the sequencer knows the vector is valid. It captures the vector, releases acknowledge and gives the core a one-cycle fetch request. The fetch address is the vector number doubled, in a 20-bit word address space. The instruction stored at that address is expected to branch to the handler.

The request line and the data lines come from outside the clock domain. Both pass through a synchroniser before the state machine looks at them. A requester might never release the request line. For that case, a programmable cycle limit ends the handshake: acknowledge drops and a timeout pulse is raised. After any release of acknowledge, the request line must be seen low before a new grant can begin.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `bus_ack_o`, `fetch_valid_o` and `timeout_o` are all low.
- R2: With `core_accept_i` high, `bus_ack_o` rises exactly three clock cycles after `bus_req_i` rises. The delay is two synchroniser stages plus one state register.
- R3: While `core_accept_i` is low, no acknowledge starts, however long the request is held. If the request is already synchronised, `bus_ack_o` rises one cycle after `core_accept_i` goes high.
- R4: `bus_ack_o` stays high until the synchronised request falls. Three cycles after `bus_req_i` falls, `bus_ack_o` drops and `fetch_valid_o` is high, both in the same cycle.
- R5: `fetch_addr_o` equals the vector sampled from `bus_data_i[7:0]`, zero-extended and multiplied by two. Bits 15:8 of the data lines have no effect. Every vector from 0x00 to 0xFF is accepted.
- R6: `fetch_valid_o` is a pulse of exactly one cycle. Each completed handshake produces exactly one such pulse.
- R7: If the request stays high for TIMEOUT_CYC cycles of acknowledge, `bus_ack_o` drops and `timeout_o` pulses for one cycle. No fetch is issued for that handshake.
- R8: After acknowledge is released, a request that is still high, or high again, starts no new acknowledge. The request line must first be seen low for at least one synchronised cycle. After that, a fresh request is granted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Shared interrupt request line, active high, asynchronous |
| bus_data_i | input | 16 | Bus data lines; bits 7:0 carry the vector |
| core_accept_i | input | 1 | Core can accept an interrupt; gates the start of a new acknowledge |
| bus_ack_o | output | 1 | Acknowledge line driven onto the bus |
| fetch_valid_o | output | 1 | One-cycle request for the core to fetch from `fetch_addr_o` |
| fetch_addr_o | output | 20 | Word address of the fetch, equal to vector times two |
| timeout_o | output | 1 | One-cycle pulse when a handshake is aborted |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- Acknowledge rises three cycles after a request edge, or one cycle after `core_accept_i` rises if the request is already synchronised.
- The fetch pulse and the release of acknowledge come three cycles after the request falls.
- The timeout pulse comes in the cycle after acknowledge has been high for TIMEOUT_CYC cycles.

The bench changes inputs on the falling clock edge and reads outputs on later falling edges. It counts exactly those cycles, and it also checks the cycle before each due point, so early outputs are caught as well as late ones. A scoreboard queue holds one expected fetch address per handshake. A monitor pops an entry on every fetch pulse, so missing pulses and extra pulses are both caught.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    // Handshake phases of the acknowledge sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for a request while the core accepts
        ST_ACK   = 2'd1,  // acknowledge driven, waiting for request release
        ST_REARM = 2'd2   // acknowledge released, waiting to see request low
    } ack_state_e;

endpackage : irq_ack_pkg

// File: rtl/irq_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
module irq_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
    end

    // Every stage after the first takes the value of the stage before it
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule : irq_sync

// File: rtl/irq_ack_fsm.sv
// Handshake state machine: grant, wait for request release, capture, rearm.
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s_i,
    input  logic [VEC_W-1:0] vec_s_i,
    input  logic             accept_i,
    output logic             ack_o,
    output logic             fire_o,
    output logic             tmo_o,
    output logic [VEC_W-1:0] vec_o
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        ack_state_e       state;
        logic             ack;
        logic             fire;
        logic             tmo;
        logic [VEC_W-1:0] vec;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.fire = 1'b0;
        regs_d.tmo  = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                regs_d.cnt = '0;
                if (req_s_i && accept_i) begin
                    regs_d.state = ST_ACK;
                    regs_d.ack   = 1'b1;
                end
            end
            ST_ACK: begin
                if (!req_s_i) begin
                    // Requester released the line while acknowledge is held:
                    // the vector on the data lines is valid now
                    regs_d.vec   = vec_s_i;
                    regs_d.fire  = 1'b1;
                    regs_d.ack   = 1'b0;
                    regs_d.state = ST_REARM;
                end else if (regs_q.cnt == CNT_LAST) begin
                    regs_d.ack   = 1'b0;
                    regs_d.tmo   = 1'b1;
                    regs_d.state = ST_REARM;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_REARM: begin
                if (!req_s_i) begin
                    regs_d.state = ST_IDLE;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
                regs_d.ack   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, ack: 1'b0, fire: 1'b0, tmo: 1'b0,
                        vec: '0, cnt: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ack_o  = regs_q.ack;
    assign fire_o = regs_q.fire;
    assign tmo_o  = regs_q.tmo;
    assign vec_o  = regs_q.vec;

    // A grant begins only while the core accepts
    assert_ack_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(accept_i));

    // A grant begins only on a synchronised request
    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_s_i));

    // Fetch follows a release of the request while acknowledge was held
    assert_capture_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ($past(ack_o) && !$past(req_s_i)));

    // Acknowledge only ever falls with a fetch or a timeout
    assert_ack_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> (fire_o || tmo_o));

    // Captured vector is the synchronised one at the release
    assert_vector_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (vec_o == $past(vec_s_i)));

    // Fetch request lasts a single cycle
    assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // Timeout and fetch never coincide; counter stays inside the window
    assert_tmo_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_o && tmo_o));
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.cnt < CNT_W'(TIMEOUT_CYC));

    // A new grant is preceded by at least two cycles without acknowledge
    assert_rearm_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> !$past(ack_o, 2));

endmodule : irq_ack_fsm

// File: rtl/irq_vec_addr.sv
// Turns a captured vector into the word address of its table entry.
module irq_vec_addr #(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 20
) (
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PAD_W = ADDR_W - VEC_W - 1;

    // Each table entry spans two words, so the address is vector * 2
    always_comb begin
        addr_o = {{PAD_W{1'b0}}, vec_i, 1'b0};
    end

endmodule : irq_vec_addr

// File: rtl/irq_ack_seq.sv
// Top: synchronises bus inputs, runs the handshake, forms the fetch address.
module irq_ack_seq #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 20,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              core_accept_i,
    output logic              bus_ack_o,
    output logic              fetch_valid_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              timeout_o
);

    localparam int SYNC_W = VEC_W + 1;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              req_s;
    logic [VEC_W-1:0]  vec_s, vec_cap;
    logic              unused_data_hi;

    // Only the vector bits of the data lines are used
    assign unused_data_hi = ^bus_data_i[DATA_W-1:VEC_W];
    assign sync_in        = {bus_req_i, bus_data_i[VEC_W-1:0]};

    irq_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    assign req_s = sync_out[SYNC_W-1];
    assign vec_s = sync_out[VEC_W-1:0];

    irq_ack_fsm #(
        .VEC_W       (VEC_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s_i  (req_s),
        .vec_s_i  (vec_s),
        .accept_i (core_accept_i),
        .ack_o    (bus_ack_o),
        .fire_o   (fetch_valid_o),
        .tmo_o    (timeout_o),
        .vec_o    (vec_cap)
    );

    irq_vec_addr #(
        .VEC_W  (VEC_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .vec_i  (vec_cap),
        .addr_o (fetch_addr_o)
    );

endmodule : irq_ack_seq

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_i = 1'b0;
    logic [15:0] bus_data_i = '0;
    logic        core_accept_i = 1'b1;
    logic        bus_ack_o, fetch_valid_o, timeout_o;
    logic [19:0] fetch_addr_o;

    int checks = 0;
    int failures = 0;
    int tmo_seen = 0;
    int fetch_seen = 0;
    logic [19:0] exp_q [$];

    always #2 clk = ~clk;

    irq_ack_seq #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req_i     (bus_req_i),
        .bus_data_i    (bus_data_i),
        .core_accept_i (core_accept_i),
        .bus_ack_o     (bus_ack_o),
        .fetch_valid_o (fetch_valid_o),
        .fetch_addr_o  (fetch_addr_o),
        .timeout_o     (timeout_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every fetch pulse (R5, R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (timeout_o) tmo_seen++;
            if (fetch_valid_o) begin
                fetch_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected fetch", {12'h0, fetch_addr_o}, 32'h0);
                end else begin
                    logic [19:0] e;
                    e = exp_q.pop_front();
                    chk(fetch_addr_o == e, "R5 fetch address", {12'h0, fetch_addr_o},
                        {12'h0, e});
                end
            end
        end
    end

    // Driver: full handshake as a well-behaved peripheral
    task automatic handshake(input logic [15:0] data);
        exp_q.push_back({11'h0, data[7:0], 1'b0});
        @(negedge clk);
        bus_data_i = data;
        bus_req_i  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(bus_ack_o == 1'b0, "R2 ack not early", {31'h0, bus_ack_o}, 32'h0);
        @(negedge clk);
        chk(bus_ack_o == 1'b1, "R2 ack after 3 cycles", {31'h0, bus_ack_o}, 32'h1);
        @(negedge clk);
        bus_req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_ack_o == 1'b1, "R4 ack held until release seen", {31'h0, bus_ack_o}, 32'h1);
        @(negedge clk);
        chk(bus_ack_o == 1'b0 && fetch_valid_o == 1'b1, "R4 release and fetch",
            {30'h0, bus_ack_o, fetch_valid_o}, 32'h1);
        @(negedge clk);
        chk(fetch_valid_o == 1'b0, "R6 fetch one cycle", {31'h0, fetch_valid_o}, 32'h0);
        bus_data_i = 16'hDEAD;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_ack_o && !fetch_valid_o && !timeout_o, "R1 in reset",
            {29'h0, bus_ack_o, fetch_valid_o, timeout_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_ack_o && !fetch_valid_o && !timeout_o, "R1 after reset",
            {29'h0, bus_ack_o, fetch_valid_o, timeout_o}, 32'h0);

        // R2 R4 R5: peripheral vectors and the extremes of the range
        handshake(16'h0010);
        handshake(16'h00FF);
        handshake(16'h0000);
        handshake(16'hA53C);   // upper data bits must be ignored (R5)

        // R3: accept low blocks the grant
        core_accept_i = 1'b0;
        exp_q.push_back(20'h00084);
        @(negedge clk);
        bus_data_i = 16'h0042;
        bus_req_i  = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(bus_ack_o == 1'b0, "R3 no ack while accept low", {31'h0, bus_ack_o}, 32'h0);
        end
        core_accept_i = 1'b1;
        @(negedge clk);
        chk(bus_ack_o == 1'b1, "R3 ack one cycle after accept", {31'h0, bus_ack_o}, 32'h1);
        bus_req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(fetch_valid_o == 1'b1, "R4 fetch after accept-gated grant",
            {31'h0, fetch_valid_o}, 32'h1);
        repeat (3) @(negedge clk);

        // R7: requester never releases
        bus_data_i = 16'h0055;
        bus_req_i  = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_ack_o == 1'b1, "R7 ack granted", {31'h0, bus_ack_o}, 32'h1);
        begin
            int hi = 0;
            while (bus_ack_o && hi < 100) begin
                hi++;
                @(negedge clk);
            end
            chk(hi == TMO, "R7 ack duration", hi, TMO);
        end
        chk(timeout_o == 1'b1 && fetch_valid_o == 1'b0, "R7 timeout pulse no fetch",
            {30'h0, timeout_o, fetch_valid_o}, 32'h2);
        @(negedge clk);
        chk(timeout_o == 1'b0, "R7 timeout one cycle", {31'h0, timeout_o}, 32'h0);

        // R8: request still high after abort must not be granted again
        begin
            bit any_ack = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (bus_ack_o) any_ack = 1'b1;
            end
            chk(!any_ack, "R8 no regrant while request held", {31'h0, any_ack}, 32'h0);
        end
        bus_req_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(bus_ack_o == 1'b0, "R8 idle after request low", {31'h0, bus_ack_o}, 32'h0);
        handshake(16'h0077);   // R8 fresh request served normally

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && fetch_seen == 6, "R6 one fetch per handshake",
            fetch_seen, 6);
        chk(tmo_seen == 1, "R7 single timeout", tmo_seen, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule : irq_ack_seq_tb